// File: doc/BRIEF.md
# Pad Boundary Scan Chain

This block sits between the core's pad-facing signals and a row of IO pads. Every pad has the same three-wire interface: data from the pad, data to the pad, and a drive enable. A per-pad type parameter selects which of those wires exist. An input pad uses only the incoming wire. An output pad uses only the outgoing wire. A tristate pad uses the outgoing wire and its enable. A bidirectional pad uses all three. Wires that a type does not have are tied to fixed values.

For every wire that exists, the block adds two scan cells and a pair of multiplexers, one facing the pad and one facing the core. The **observe** cell captures whatever flows into the block on that wire. The **force** cell holds a value that can replace the wire's destination.

When test mode is low, the multiplexers pass signals straight through. When test mode is high:

- the pad side is driven from force cells, so the test controller can set pad levels and enables;
- the core side is driven from different force cells, so the core can be stimulated separately;
- the observe cells record what arrives from either side.

An external test access controller runs the chain with three strobes (capture, shift, update), a serial input, a serial output and the test-mode select. All of them are sampled on `clk`, and `rst_n` is an asynchronous reset.

Top module: `pad_bscan_chain`

## Requirements
- R1: The pad type code for pad p sits in `PAD_TYPES[2p+1:2p]`, with 0 = input, 1 = output, 2 = tristate and 3 = bidirectional. Wires that a type lacks are tied off: `pad_o` is 0 for input pads, `pad_oe` is 0 for input pads and 1 for output pads, and `core_i` is 0 for output and tristate pads.
- R2: With `test_mode` low, `pad_o` = `core_o`, `pad_oe` = `core_oe` and `core_i` = `pad_i` on every wire that the pad's type has. This holds in the same cycle, whatever the scan cells contain.
- R3: With `test_mode` high, the wires that each pad has take their values from force-cell hold latches. These are `pad_o` and `pad_oe` on the pad side and `core_i` on the core side. Changes on `core_o`, `core_oe` and `pad_i` have no effect on them.
- R4: The chain is ordered by pad index, ascending. Within a pad the wires run input, output, enable. Within a wire the pad-side cell comes before the core-side cell. The chain length is twice the number of wires. `scan_in` enters position 0, and `scan_out` is the register at the last position.
- R5: A cycle with `shift_en` high and `capture_en` low moves every cell one position toward `scan_out` and loads `scan_in` into position 0.
- R6: A cycle with `capture_en` high loads each observe cell with its incoming value (`pad_i`, `core_o` or `core_oe`). In the same cycle, each force cell reloads its own hold latch value.
- R7: When `capture_en` and `shift_en` are both high in a cycle, the capture takes effect and no shift happens.
- R8: A cycle with `update_en` high copies every shift cell into its hold latch. Hold latches do not change in any other cycle, so the forced outputs stay steady during shifting.
- R9: When `update_en` and `shift_en` are high in the same cycle, the hold latches receive the chain contents from before that shift.
- R10: While `rst_n` is low, all shift cells and hold latches are zero. As a result `scan_out` is 0 and, in test mode, every tristate and bidirectional enable is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all scan cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects scan values on the multiplexers |
| capture_en | input | 1 | Parallel load of observed values |
| shift_en | input | 1 | Serial shift of the chain by one position |
| update_en | input | 1 | Copy of shift cells into hold latches |
| scan_in | input | 1 | Serial data into chain position 0 |
| scan_out | output | 1 | Serial data from the last chain position |
| core_o | input | NUM_PADS | Core data toward each pad |
| core_oe | input | NUM_PADS | Core drive enable for each pad |
| core_i | output | NUM_PADS | Pad data delivered to the core |
| pad_i | input | NUM_PADS | Data received from each pad |
| pad_o | output | NUM_PADS | Data driven onto each pad |
| pad_oe | output | NUM_PADS | Drive enable for each pad |

## Verification
The operations that can land on the same edge are shift and update, and shift and capture. The bench provokes shift and update together by loading a known chain image, then raising both strobes for one cycle with a fresh serial bit. It then checks that the forced outputs match the image from before the shift. A second update alone must expose the shifted image. Capture and shift are raised together on known pad and core levels, and the unloaded chain must match the captured pattern with no shifted bit in it.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    PAD_IN    = 2'd0,
    PAD_OUT   = 2'd1,
    PAD_TRI   = 2'd2,
    PAD_BIDIR = 2'd3
  } pad_kind_e;

  function automatic int wires_of(input logic [1:0] kind);
    case (kind)
      2'd0:    return 1;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_in,
  input  logic cap_val,
  output logic sr_q,
  output logic hold_q
);

  // shift stage: capture has priority over shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= 1'b0;
    else if (capture_en) sr_q <= cap_val;
    else if (shift_en)   sr_q <= ser_in;
  end

  // hold stage: takes the pre-edge shift value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (update_en) hold_q <= sr_q;
  end

  // R6
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (sr_q == $past(cap_val)));

  // R5
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (sr_q == $past(ser_in)));

  // R8
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> (hold_q == $past(sr_q)));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(hold_q));

  // R7
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !shift_en) |=> $stable(sr_q));

endmodule

// File: rtl/bscan_wire_tap.sv
module bscan_wire_tap #(
  parameter bit OBSERVE_PAD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_in,
  output logic ser_out,
  input  logic src,
  output logic dst
);

  logic mid;
  logic obs_sr, obs_hold_unused;
  logic frc_sr, frc_hold;

  // observe cell captures the incoming wire; force cell recaptures its hold
  if (OBSERVE_PAD) begin : g_pad_obs
    bscan_cell u_obs (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .update_en(update_en), .ser_in(ser_in), .cap_val(src),
      .sr_q(obs_sr), .hold_q(obs_hold_unused));
    bscan_cell u_frc (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .update_en(update_en), .ser_in(mid), .cap_val(frc_hold),
      .sr_q(frc_sr), .hold_q(frc_hold));
    assign mid     = obs_sr;
    assign ser_out = frc_sr;
  end else begin : g_pad_frc
    bscan_cell u_frc (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .update_en(update_en), .ser_in(ser_in), .cap_val(frc_hold),
      .sr_q(frc_sr), .hold_q(frc_hold));
    bscan_cell u_obs (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .update_en(update_en), .ser_in(mid), .cap_val(src),
      .sr_q(obs_sr), .hold_q(obs_hold_unused));
    assign mid     = frc_sr;
    assign ser_out = obs_sr;
  end

  // destination-side multiplexer
  assign dst = test_mode ? frc_hold : src;

  // R8
  frozen_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && $past(test_mode) && !$past(update_en)) |-> $stable(dst));

endmodule

// File: rtl/bscan_pad_tap.sv
module bscan_pad_tap
  import bscan_pkg::*;
#(
  parameter logic [1:0] KIND = 2'd3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic ser_in,
  output logic ser_out,
  input  logic core_o,
  input  logic core_oe,
  output logic core_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe
);

  localparam int NW = wires_of(KIND);

  logic [NW:0] link;
  assign link[0] = ser_in;
  assign ser_out = link[NW];

  if (KIND == PAD_IN) begin : g_in
    logic unused_in;
    bscan_wire_tap #(.OBSERVE_PAD(1'b1)) u_i (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[0]),
      .ser_out(link[1]), .src(pad_i), .dst(core_i));
    assign pad_o     = 1'b0;
    assign pad_oe    = 1'b0;
    assign unused_in = core_o ^ core_oe;
  end else if (KIND == PAD_OUT) begin : g_out
    logic unused_out;
    bscan_wire_tap #(.OBSERVE_PAD(1'b0)) u_o (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[0]),
      .ser_out(link[1]), .src(core_o), .dst(pad_o));
    assign pad_oe     = 1'b1;
    assign core_i     = 1'b0;
    assign unused_out = pad_i ^ core_oe;
  end else if (KIND == PAD_TRI) begin : g_tri
    logic unused_tri;
    bscan_wire_tap #(.OBSERVE_PAD(1'b0)) u_o (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[0]),
      .ser_out(link[1]), .src(core_o), .dst(pad_o));
    bscan_wire_tap #(.OBSERVE_PAD(1'b0)) u_e (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[1]),
      .ser_out(link[2]), .src(core_oe), .dst(pad_oe));
    assign core_i     = 1'b0;
    assign unused_tri = pad_i;
  end else begin : g_bidir
    bscan_wire_tap #(.OBSERVE_PAD(1'b1)) u_i (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[0]),
      .ser_out(link[1]), .src(pad_i), .dst(core_i));
    bscan_wire_tap #(.OBSERVE_PAD(1'b0)) u_o (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[1]),
      .ser_out(link[2]), .src(core_o), .dst(pad_o));
    bscan_wire_tap #(.OBSERVE_PAD(1'b0)) u_e (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
      .shift_en(shift_en), .update_en(update_en), .ser_in(link[2]),
      .ser_out(link[3]), .src(core_oe), .dst(pad_oe));
  end

endmodule

// File: rtl/pad_bscan_chain.sv
module pad_bscan_chain
  import bscan_pkg::*;
#(
  parameter int                    NUM_PADS  = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_TYPES = 8'hE4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_mode,
  input  logic                capture_en,
  input  logic                shift_en,
  input  logic                update_en,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic [NUM_PADS-1:0] core_o,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_i,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] pad_oe
);

  // wire count ahead of pad p; each wire holds two cells
  function automatic int wire_base(input int p);
    int acc = 0;
    for (int q = 0; q < p; q++) acc += wires_of(PAD_TYPES[2*q +: 2]);
    return acc;
  endfunction

  localparam int TOTAL_WIRES = wire_base(NUM_PADS);

  logic [TOTAL_WIRES:0] link;
  assign link[0]  = scan_in;
  assign scan_out = link[TOTAL_WIRES];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int LO = wire_base(p);
    localparam int HI = wire_base(p + 1);
    bscan_pad_tap #(.KIND(PAD_TYPES[2*p +: 2])) u_pad (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
      .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
      .ser_in(link[LO]), .ser_out(link[HI]),
      .core_o(core_o[p]), .core_oe(core_oe[p]), .core_i(core_i[p]),
      .pad_i(pad_i[p]), .pad_o(pad_o[p]), .pad_oe(pad_oe[p]));
  end

  // R7
  cap_beats_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && shift_en && !update_en) |=> ($stable(pad_o) || !test_mode));

endmodule

// File: tb/tb_pad_bscan_chain.sv
module tb_pad_bscan_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int L  = 14;

  logic clk = 1'b0;
  logic rst_n, test_mode, capture_en, shift_en, update_en, scan_in;
  logic scan_out;
  logic [NP-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;

  int errors = 0;
  int checks = 0;
  logic [L-1:0] S = '0;  // model of shift cells
  logic [L-1:0] H = '0;  // model of hold latches

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_bscan_chain #(.NUM_PADS(NP), .PAD_TYPES(8'hE4)) dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
    .scan_out(scan_out), .core_o(core_o), .core_oe(core_oe), .core_i(core_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe));

  // pads: 0 input, 1 output, 2 tristate, 3 bidirectional
  function automatic logic [11:0] view_test(input logic [L-1:0] h);
    return {h[10], h[4], h[2], 1'b0, h[12], h[6], 1'b1, 1'b0,
            h[9], 1'b0, 1'b0, h[1]};
  endfunction

  function automatic logic [11:0] view_norm(input logic [3:0] co, coe, pi);
    return {co[3], co[2], co[1], 1'b0, coe[3], coe[2], 1'b1, 1'b0,
            pi[3], 1'b0, 1'b0, pi[0]};
  endfunction

  function automatic logic [L-1:0] cap_model(input logic [L-1:0] h,
                                             input logic [3:0] pi, co, coe);
    logic [L-1:0] r = h;
    r[0] = pi[0]; r[3] = co[1]; r[5] = co[2]; r[7] = coe[2];
    r[8] = pi[3]; r[11] = co[3]; r[13] = coe[3];
    return r;
  endfunction

  function automatic logic [L-1:0] place(input logic [6:0] frc, obs);
    logic [L-1:0] r;
    r[1] = frc[0]; r[2] = frc[1]; r[4] = frc[2]; r[6] = frc[3];
    r[9] = frc[4]; r[10] = frc[5]; r[12] = frc[6];
    r[0] = obs[0]; r[3] = obs[1]; r[5] = obs[2]; r[7] = obs[3];
    r[8] = obs[4]; r[11] = obs[5]; r[13] = obs[6];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shifts v in (bit 13 first) and collects the old chain contents
  task automatic shift_word(input logic [L-1:0] v, output logic [L-1:0] got);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      shift_en = 1'b1;
      scan_in  = v[L-1-k];
      core_o   = 4'(k * 5);
      core_oe  = 4'(k * 3 + 1);
      pad_i    = 4'(~k);
      #1;
      got[L-1-k] = scan_out;
      // R3 R8: forced values ignore inputs and hold during shifting
      chk("R3/R8 steady while shifting", {pad_o, pad_oe, core_i}, view_test(H));
      @(posedge clk);
      S = {S[L-2:0], v[L-1-k]};
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
    H = S;
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [L-1:0] got, v1, prev;
    rst_n = 1'b0; test_mode = 1'b1; capture_en = 1'b0; shift_en = 1'b0;
    update_en = 1'b0; scan_in = 1'b0; core_o = '1; core_oe = '1; pad_i = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {pad_o, pad_oe, core_i}, view_test('0));
    chk("R10 reset scan_out", scan_out, 1'b0);
    rst_n = 1'b1;

    shift_word('0, got);
    chk("R10 chain cleared", got, '0);

    // R4 R5 R8 R3: sweep every force pattern
    prev = '0;
    for (int v = 0; v < 128; v++) begin
      logic [L-1:0] img;
      img = place(7'(v), ~7'(v));
      shift_word(img, got);
      chk("R4/R5 readback order", got, prev);
      pulse_update();
      chk("R8/R3 forced outputs", {pad_o, pad_oe, core_i}, view_test(img));
      prev = img;
    end

    // R6 capture sweep over all pad and core levels
    for (int x = 0; x < 4096; x++) begin
      logic [L-1:0] expv;
      @(negedge clk);
      {pad_i, core_o, core_oe} = 12'(x);
      capture_en = 1'b1;
      @(negedge clk);
      capture_en = 1'b0;
      expv = cap_model(H, pad_i, core_o, core_oe);
      S = expv;
      shift_word('0, got);
      chk("R6 captured pattern", got, expv);
    end

    // R7 capture and shift together
    @(negedge clk);
    pad_i = 4'b1001; core_o = 4'b0110; core_oe = 4'b1100;
    capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
    @(negedge clk);
    capture_en = 1'b0; shift_en = 1'b0;
    S = cap_model(H, 4'b1001, 4'b0110, 4'b1100);
    v1 = S;
    shift_word('0, got);
    chk("R7 capture wins over shift", got, v1);

    // R9 update and shift together
    v1 = 14'h2A5B;
    shift_word(v1, got);
    @(negedge clk);
    shift_en = 1'b1; update_en = 1'b1; scan_in = 1'b1;
    @(negedge clk);
    shift_en = 1'b0; update_en = 1'b0;
    H = v1;
    S = {v1[L-2:0], 1'b1};
    #1;
    chk("R9 update takes pre-shift image", {pad_o, pad_oe, core_i}, view_test(v1));
    pulse_update();
    chk("R9 later update exposes shifted image", {pad_o, pad_oe, core_i}, view_test(S));

    // R1 R2 normal-mode sweep with non-zero hold latches
    test_mode = 1'b0;
    for (int x = 0; x < 4096; x++) begin
      {pad_i, core_o, core_oe} = 12'(x);
      #1;
      chk("R1/R2 pass-through and tie-offs", {pad_o, pad_oe, core_i},
          view_norm(core_o, core_oe, pad_i));
    end
    @(negedge clk);
    test_mode = 1'b1;
    #1;
    chk("R8 hold kept across normal mode", {pad_o, pad_oe, core_i}, view_test(H));

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears hold", {pad_o, pad_oe, core_i}, view_test('0));
    chk("R10 reset clears scan_out", scan_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    S = '0; H = '0;
    shift_word('0, got);
    chk("R10 reset clears chain", got, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule